// File: doc/BRIEF.md
# Interleaved Partial-Sum Accumulator

This block sums a stream of packed groups of unsigned integer elements. Each input beat carries `N` elements. The block keeps `P × N` wide partial-sum lanes, split into `P` segments of `N` lanes, with `P` equal to the adder latency `LAT`. Successive beats are added into successive segments and wrap back to segment 0 after segment `P-1`. A pipelined adder can therefore take a new beat on every cycle, and it never reads a lane whose previous update is still in the pipeline.

When the beat flagged as last has been taken, the block stops accepting input and waits for the adder pipeline to empty. It then folds the segments into one scalar, one segment per cycle, and presents the total for one cycle. It clears its lanes for the next stream at the same time.

In parallel, a section path cuts the same element stream into sections of `k` consecutive elements and emits one sum per section on a separate output. Section boundaries may fall inside a beat. The section size is taken from `sec_size_i` on the first beat of a stream. A value of zero turns the section path off.

Top module: `ilv_psum_acc`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `in_ready_o` is 1 and both `sec_valid_o` and `res_valid_o` are 0.
- R2: A beat is taken on a clock edge where `in_valid_i` and `in_ready_o` are both 1. After a beat with `in_last_i` = 1 is taken, `in_ready_o` stays 0 until the cycle in which `res_valid_o` is 1. In that cycle it is 1 again.
- R3: Beats are added round-robin into `P = LAT` segments of `N` lanes and wrap after segment `P-1`. A segment is never issued to the adder while an earlier add to it is still in flight.
- R4: `res_sum_o` equals the sum of every element of the stream. `res_valid_o` is a single-cycle pulse.
- R5: The final reduction starts only after every in-flight add has been written back, so the last beat of the stream is always included.
- R6: Element `i` of a beat sits in `in_data_i[i*ELEM_W +: ELEM_W]`, and element 0 comes first in stream order. With a section size `k > 0`, each run of `k` consecutive elements produces exactly one `sec_valid_o` pulse carrying its sum.
- R7: When a section ends inside a beat, the remaining elements of that beat begin the next section's sum.
- R8: If the stream ends partway through a section, that partial sum is emitted once, after the last beat. If the stream ends exactly on a boundary, no extra section is emitted.
- R9: `sec_size_i` = 0 on the first beat disables section output for the whole stream.
- R10: A section size from 1 to `N-1` is treated as `N`.
- R11: The section size is sampled on the first beat of a stream. Changes to `sec_size_i` during the stream have no effect.
- R12: The lanes are cleared when the result is emitted, so a following stream's total does not include earlier data.
- R13: Lanes are `ACC_W` bits wide, so a stream of 64 beats of all-ones 8-bit elements sums to 65280 exactly, with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Block can take a beat |
| in_data_i | input | N*ELEM_W | Packed elements, element 0 in the low bits |
| in_last_i | input | 1 | Beat is the last of the stream |
| sec_size_i | input | KW | Elements per section, 0 = off |
| sec_valid_o | output | 1 | Section sum valid (one-cycle pulse) |
| sec_sum_o | output | ACC_W | Section sum |
| res_valid_o | output | 1 | Stream total valid (one-cycle pulse) |
| res_sum_o | output | ACC_W | Stream total |

## Verification
On every cycle, the embedded properties check three things:
- The adder never receives a segment that is still in its pipeline.
- The reduction never runs while adds are pending.
- The section counter stays below the section size, the lanes are zero when the total is presented, and input stays blocked after a last beat.

Whether the totals and section sums are numerically right is shown only by the bench. It compares them against a sequential model over varied stream lengths, section sizes, idle gaps, mid-stream size changes, boundaries that land inside a beat or exactly at stream end, and saturated input.

// File: rtl/ilv_psum_pkg.sv
package ilv_psum_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_RED   = 2'd2
  } psum_st_e;
endpackage

// File: rtl/ilv_psum_pipe.sv
module ilv_psum_pipe #(
  parameter int N      = 4,
  parameter int ELEM_W = 8,
  parameter int ACC_W  = 24,
  parameter int LAT    = 3,
  parameter int SEG_W  = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        issue_i,
  input  logic [SEG_W-1:0]            issue_seg_i,
  input  logic [N-1:0][ACC_W-1:0]     lane_i,
  input  logic [N-1:0][ELEM_W-1:0]    elem_i,
  output logic                        wr_valid_o,
  output logic [SEG_W-1:0]            wr_seg_o,
  output logic [N-1:0][ACC_W-1:0]     wr_data_o,
  output logic                        busy_o
);
  localparam int STAGES = LAT - 1;

  logic [STAGES-1:0]          v_q;
  logic [SEG_W-1:0]           seg_q [STAGES];
  logic [N-1:0][ACC_W-1:0]    dat_q [STAGES];
  logic [N-1:0][ACC_W-1:0]    sum_d;

  always_comb begin
    for (int i = 0; i < N; i++) sum_d[i] = lane_i[i] + ACC_W'(elem_i[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0;
      for (int s = 0; s < STAGES; s++) begin
        seg_q[s] <= '0;
        dat_q[s] <= '0;
      end
    end else begin
      v_q[0] <= issue_i;
      if (issue_i) begin
        seg_q[0] <= issue_seg_i;
        dat_q[0] <= sum_d;
      end
      for (int s = 1; s < STAGES; s++) begin
        v_q[s] <= v_q[s-1];
        if (v_q[s-1]) begin
          seg_q[s] <= seg_q[s-1];
          dat_q[s] <= dat_q[s-1];
        end
      end
    end
  end

  assign wr_valid_o = v_q[STAGES-1];
  assign wr_seg_o   = seg_q[STAGES-1];
  assign wr_data_o  = dat_q[STAGES-1];
  assign busy_o     = |v_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_haz
    // R3
    no_seg_reissue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (issue_i && v_q[s]) |-> (issue_seg_i != seg_q[s]));
  end
endmodule

// File: rtl/ilv_psum_section.sv
module ilv_psum_section #(
  parameter int N      = 4,
  parameter int ELEM_W = 8,
  parameter int ACC_W  = 24,
  parameter int KW     = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      beat_i,
  input  logic                      last_i,
  input  logic [N-1:0][ELEM_W-1:0]  elem_i,
  input  logic [KW-1:0]             size_i,
  output logic                      sec_valid_o,
  output logic [ACC_W-1:0]          sec_sum_o
);
  localparam int CW = KW + 1;

  logic             in_stream_q, flush_q, sec_valid_q;
  logic [KW-1:0]    k_q, k_raw, k_eff;
  logic [CW-1:0]    cnt_q, cnt_nxt, rem;
  logic [ACC_W-1:0] acc_q, acc_nxt, sec_sum_q, head, tail;
  logic [ACC_W-1:0] pre [N+1];
  logic             en, hit, flush_need;

  assign k_raw = in_stream_q ? k_q : size_i;
  assign k_eff = (k_raw != '0 && k_raw < KW'(N)) ? KW'(N) : k_raw;
  assign en    = (k_eff != '0);
  assign rem   = CW'(k_eff) - cnt_q;
  assign hit   = en && (rem <= CW'(N));

  always_comb begin
    pre[0] = '0;
    for (int j = 0; j < N; j++) pre[j+1] = pre[j] + ACC_W'(elem_i[j]);
    head = '0;
    for (int j = 0; j <= N; j++) if (rem == CW'(j)) head = pre[j];
    tail = pre[N] - head;
  end

  // boundary inside the beat: remainder opens the next section
  assign cnt_nxt    = !en ? '0 : (hit ? CW'(N) - rem : cnt_q + CW'(N));
  assign acc_nxt    = !en ? '0 : (hit ? tail : acc_q + pre[N]);
  assign flush_need = en && (cnt_nxt != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_stream_q <= 1'b0;
      flush_q     <= 1'b0;
      sec_valid_q <= 1'b0;
      sec_sum_q   <= '0;
      k_q         <= '0;
      cnt_q       <= '0;
      acc_q       <= '0;
    end else begin
      sec_valid_q <= 1'b0;
      if (flush_q) begin
        sec_valid_q <= 1'b1;
        sec_sum_q   <= acc_q;
        acc_q       <= '0;
        cnt_q       <= '0;
        flush_q     <= 1'b0;
      end else if (beat_i) begin
        k_q         <= k_eff;
        in_stream_q <= !last_i;
        if (hit) begin
          sec_valid_q <= 1'b1;
          sec_sum_q   <= acc_q + head;
        end
        if (last_i && !flush_need) begin
          acc_q <= '0;
          cnt_q <= '0;
        end else begin
          acc_q <= acc_nxt;
          cnt_q <= cnt_nxt;
        end
        flush_q <= last_i && flush_need;
      end
    end
  end

  assign sec_valid_o = sec_valid_q;
  assign sec_sum_o   = sec_sum_q;

  // R6
  sec_cnt_below_k_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_stream_q && k_q != '0) |-> (cnt_q < CW'(k_q)));
  // R8
  flush_no_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_q |-> !beat_i);
  // R9
  sec_off_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_i && !en) |=> !sec_valid_o);
endmodule

// File: rtl/ilv_psum_reduce.sv
module ilv_psum_reduce #(
  parameter int N     = 4,
  parameter int ACC_W = 24,
  parameter int P     = 3,
  parameter int SEG_W = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     busy_i,
  input  logic [N-1:0][ACC_W-1:0]  seg_lanes_i,
  output logic [SEG_W-1:0]         rd_seg_o,
  output logic                     last_o,
  output logic                     done_o,
  output logic [ACC_W-1:0]         sum_o
);
  logic             active_q, done_q;
  logic [SEG_W-1:0] idx_q;
  logic [ACC_W-1:0] acc_q, sum_q, seg_tot;

  always_comb begin
    seg_tot = '0;
    for (int i = 0; i < N; i++) seg_tot = seg_tot + seg_lanes_i[i];
  end

  assign last_o = active_q && (idx_q == SEG_W'(P - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      idx_q    <= '0;
      acc_q    <= '0;
      sum_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        active_q <= 1'b1;
        idx_q    <= '0;
        acc_q    <= '0;
      end else if (active_q) begin
        if (last_o) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
          sum_q    <= acc_q + seg_tot;
        end else begin
          acc_q <= acc_q + seg_tot;
          idx_q <= idx_q + SEG_W'(1);
        end
      end
    end
  end

  assign rd_seg_o = idx_q;
  assign done_o   = done_q;
  assign sum_o    = sum_q;

  // R5
  red_after_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> !busy_i);
  // R5
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !active_q);
  // R4
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/ilv_psum_acc.sv
module ilv_psum_acc #(
  parameter int N      = 4,
  parameter int ELEM_W = 8,
  parameter int ACC_W  = 24,
  parameter int LAT    = 3,
  parameter int KW     = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  in_valid_i,
  output logic                  in_ready_o,
  input  logic [N*ELEM_W-1:0]   in_data_i,
  input  logic                  in_last_i,
  input  logic [KW-1:0]         sec_size_i,
  output logic                  sec_valid_o,
  output logic [ACC_W-1:0]      sec_sum_o,
  output logic                  res_valid_o,
  output logic [ACC_W-1:0]      res_sum_o
);
  import ilv_psum_pkg::*;

  localparam int P     = LAT;
  localparam int SEG_W = (P > 1) ? $clog2(P) : 1;

  psum_st_e                 st_q;
  logic [SEG_W-1:0]         seg_q, wr_seg, rd_seg;
  logic [N-1:0][ACC_W-1:0]  lane_q [P];
  logic [N-1:0][ELEM_W-1:0] elem_v;
  logic [N-1:0][ACC_W-1:0]  wr_data;
  logic                     accept, wr_valid, busy, red_start, red_last, lane_nz;

  assign elem_v     = in_data_i;
  assign in_ready_o = (st_q == ST_RUN);
  assign accept     = in_valid_i && in_ready_o;
  assign red_start  = (st_q == ST_DRAIN) && !busy;

  ilv_psum_pipe #(.N(N), .ELEM_W(ELEM_W), .ACC_W(ACC_W), .LAT(LAT), .SEG_W(SEG_W)) u_pipe (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .issue_i     (accept),
    .issue_seg_i (seg_q),
    .lane_i      (lane_q[seg_q]),
    .elem_i      (elem_v),
    .wr_valid_o  (wr_valid),
    .wr_seg_o    (wr_seg),
    .wr_data_o   (wr_data),
    .busy_o      (busy)
  );

  ilv_psum_reduce #(.N(N), .ACC_W(ACC_W), .P(P), .SEG_W(SEG_W)) u_red (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (red_start),
    .busy_i      (busy),
    .seg_lanes_i (lane_q[rd_seg]),
    .rd_seg_o    (rd_seg),
    .last_o      (red_last),
    .done_o      (res_valid_o),
    .sum_o       (res_sum_o)
  );

  ilv_psum_section #(.N(N), .ELEM_W(ELEM_W), .ACC_W(ACC_W), .KW(KW)) u_sec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .beat_i      (accept),
    .last_i      (in_last_i),
    .elem_i      (elem_v),
    .size_i      (sec_size_i),
    .sec_valid_o (sec_valid_o),
    .sec_sum_o   (sec_sum_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_RUN;
    end else begin
      unique case (st_q)
        ST_RUN:   if (accept && in_last_i) st_q <= ST_DRAIN;
        ST_DRAIN: if (!busy)               st_q <= ST_RED;
        ST_RED:   if (red_last)            st_q <= ST_RUN;
        default:                           st_q <= ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       seg_q <= '0;
    else if (red_last) seg_q <= '0;
    else if (accept)   seg_q <= (seg_q == SEG_W'(P - 1)) ? '0 : seg_q + SEG_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < P; s++) lane_q[s] <= '0;
    end else if (red_last) begin
      for (int s = 0; s < P; s++) lane_q[s] <= '0;
    end else if (wr_valid) begin
      lane_q[wr_seg] <= wr_data;
    end
  end

  always_comb begin
    lane_nz = 1'b0;
    for (int s = 0; s < P; s++)
      for (int i = 0; i < N; i++) lane_nz = lane_nz | (|lane_q[s][i]);
  end

  // R2
  last_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && in_last_i) |=> !in_ready_o);
  // R2
  ready_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> in_ready_o);
  // R3
  seg_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_q < SEG_W'(P));
  // R12
  lanes_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> !lane_nz);
endmodule

// File: tb/ilv_psum_acc_tb.sv
`timescale 1ns/1ps
module ilv_psum_acc_tb;
  localparam int N = 4, EW = 8, AW = 24, LAT = 3, KW = 8;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            in_valid_i = 1'b0;
  logic            in_ready_o;
  logic [N*EW-1:0] in_data_i = '0;
  logic            in_last_i = 1'b0;
  logic [KW-1:0]   sec_size_i = '0;
  logic            sec_valid_o;
  logic [AW-1:0]   sec_sum_o;
  logic            res_valid_o;
  logic [AW-1:0]   res_sum_o;

  always #4 clk_i = ~clk_i;

  ilv_psum_acc #(.N(N), .ELEM_W(EW), .ACC_W(AW), .LAT(LAT), .KW(KW)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .in_data_i(in_data_i), .in_last_i(in_last_i), .sec_size_i(sec_size_i),
    .sec_valid_o(sec_valid_o), .sec_sum_o(sec_sum_o),
    .res_valid_o(res_valid_o), .res_sum_o(res_sum_o));

  // beats, seed, section size
  localparam int TBL [8][3] = '{
    '{1, 1, 0}, '{2, 7, 4}, '{3, 11, 5}, '{7, 3, 6},
    '{10, 5, 3}, '{13, 9, 9}, '{20, 13, 1}, '{17, 21, 16}};

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int elems [1024];
  int exp_sec [512];
  int exp_n;
  longint exp_tot;
  int got_sec [512];
  int got_n = 0;
  longint got_res;
  bit got_seen = 0, got_ready = 0;

  always @(negedge clk_i) begin
    if (sec_valid_o && got_n < 512) begin
      got_sec[got_n] = int'(sec_sum_o);
      got_n++;
    end
    if (res_valid_o) begin
      got_seen  = 1;
      got_res   = longint'(res_sum_o);
      got_ready = in_ready_o;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_stream(input int beats, input int seed, input int k, input int k_mid,
                            input bit all_max, input string tag_tot, input string tag_cnt,
                            input string tag_val);
    int unsigned st;
    int ke, acc, cnt;
    st = seed;
    exp_tot = 0;
    for (int i = 0; i < beats * N; i++) begin
      st = st * 1664525 + 1013904223;
      elems[i] = all_max ? 255 : int'((st >> 16) & 255);
      exp_tot += elems[i];
    end
    ke = (k != 0 && k < N) ? N : k;
    exp_n = 0;
    if (ke > 0) begin
      acc = 0; cnt = 0;
      for (int i = 0; i < beats * N; i++) begin
        acc += elems[i]; cnt++;
        if (cnt == ke) begin exp_sec[exp_n] = acc; exp_n++; acc = 0; cnt = 0; end
      end
      if (cnt > 0) begin exp_sec[exp_n] = acc; exp_n++; end
    end
    got_n = 0;
    got_seen = 0;
    for (int b = 0; b < beats; b++) begin
      @(negedge clk_i);
      if (((b + seed) % 3) == 0) begin
        in_valid_i = 0;
        @(negedge clk_i);
      end
      in_valid_i = 1;
      for (int i = 0; i < N; i++) in_data_i[i*EW +: EW] = EW'(elems[b*N + i]);
      in_last_i  = (b == beats - 1);
      sec_size_i = (k_mid >= 0 && b > 0) ? KW'(k_mid) : KW'(k);
      @(posedge clk_i);
    end
    @(negedge clk_i);
    in_valid_i = 0;
    in_last_i  = 0;
    chk(in_ready_o == 1'b0, "R2", "ready after last beat", in_ready_o, 0);
    for (int w = 0; w < 200 && !got_seen; w++) @(posedge clk_i);
    chk(got_seen, "R4", "result pulse seen", got_seen, 1);
    chk(got_res == exp_tot, tag_tot, "stream total", got_res, exp_tot);
    chk(got_ready, "R2", "ready with result", got_ready, 1);
    chk(got_n == exp_n, tag_cnt, "section count", got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++)
      chk(got_sec[i] == exp_sec[i], tag_val, $sformatf("section %0d sum", i),
          got_sec[i], exp_sec[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(in_ready_o == 1'b1, "R1", "ready in reset", in_ready_o, 1);
    chk(res_valid_o == 1'b0, "R1", "result valid in reset", res_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(in_ready_o == 1'b1, "R1", "ready after reset", in_ready_o, 1);
    chk(sec_valid_o == 1'b0, "R1", "section valid after reset", sec_valid_o, 0);
    chk(res_valid_o == 1'b0, "R1", "result valid after reset", res_valid_o, 0);

    for (int r = 0; r < 8; r++) begin
      int bt, kk, ke;
      string tt, tc, tv;
      bt = TBL[r][0]; kk = TBL[r][2];
      ke = (kk != 0 && kk < N) ? N : kk;
      tt = (bt == 1) ? "R5" : ((bt > LAT) ? "R3" : "R4");
      if (kk == 0)                     begin tc = "R9"; tv = "R9"; end
      else if (kk < N)                 begin tc = "R10"; tv = "R10"; end
      else begin
        tc = (((bt * N) % ke) != 0) ? "R8" : "R6";
        tv = ((ke % N) != 0) ? "R7" : "R6";
      end
      run_stream(bt, TBL[r][1], kk, -1, 0, tt, tc, tv);
    end

    // stream ends exactly on a section boundary
    run_stream(3, 17, 6, -1, 0, "R4", "R8", "R7");
    // size change mid-stream is ignored
    run_stream(6, 4, 5, 8, 0, "R4", "R11", "R11");
    // back-to-back after previous result: lanes start clean
    run_stream(5, 8, 4, -1, 0, "R12", "R6", "R6");
    // saturated elements, long stream
    run_stream(64, 2, 0, -1, 1, "R13", "R9", "R9");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule